// File: doc/BRIEF.md
# Asynchronous Host Bus Register Interface

This block connects an eight-location, byte-wide peripheral register file to an asynchronous 8-bit host bus. The host drives three chip selects of mixed polarity, an active-low address strobe, a 3-bit address, read and write strobes that each come in an active-low and an active-high form, and a data bus. The bidirectional data bus is modelled as a separate input byte, output byte and output enable. Every host input is oversampled by a fast system clock through a synchronizer. The block then combines the strobes, qualifies the access with the chip selects and tracks the address.

Each access reaches the register file as a single-cycle request that carries the held address. A read request is issued when the read strobe becomes active. The register byte returned on `rd_data_i` is driven onto the bus for as long as the read lasts. A write request is issued when the write strobe goes inactive. It carries the last data byte seen while the strobe was active.

The address and chip selects are captured when the address strobe falls. If the address strobe is tied low, they are captured instead at the start of each access. Either way, the host may change them once the access has begun.

Top module: `hbus_regif`

## Requirements
- R1: The block counts as selected only when `cs_a_i` is 1, `cs_b_i` is 1 and `cs_c_n_i` is 0, as captured for the access. An access made while not selected produces no `rd_req_o`, no `wr_req_o` and no `bus_oe_o`.
- R2: A read is active while `rd_n_i` is 0 or `rd_i` is 1. A write is active while `wr_n_i` is 0 or `wr_i` is 1. Each of the two polarities alone performs a complete access.
- R3: Each selected read produces exactly one `rd_req_o` pulse, one clock wide, at the start of the read, with `req_addr_o` holding the captured address.
- R4: Each selected write produces exactly one `wr_req_o` pulse, one clock wide, after the write strobe goes inactive. `wr_data_o` holds the last `bus_d_i` byte sampled while the strobe was active. Data changed together with the strobe release is not used.
- R5: `bus_oe_o` is 1 only while a read is active and the access is selected. While it is 1, `bus_d_o` equals `rd_data_i`; otherwise `bus_d_o` is 0.
- R6: When `astb_n_i` falls before an access, the address and chip selects present at that fall are used for the whole access. Changes to them after the strobe edge are ignored.
- R7: With `astb_n_i` held at 0, the address and chip selects present when the access strobe becomes active are used. A change as soon as one clock after the strobe edge is ignored.
- R8: While `rst_n` is 0, and after reset, `rd_req_o`, `wr_req_o`, `bus_oe_o` and `bus_d_o` are 0. A write whose strobe is released during reset produces no request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the host bus |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_a_i | input | 1 | Chip select, active high |
| cs_b_i | input | 1 | Chip select, active high |
| cs_c_n_i | input | 1 | Chip select, active low |
| astb_n_i | input | 1 | Address strobe, active low; capture on falling edge |
| addr_i | input | 3 | Register address from host |
| rd_n_i | input | 1 | Read strobe, active low |
| rd_i | input | 1 | Read strobe, active high |
| wr_n_i | input | 1 | Write strobe, active low |
| wr_i | input | 1 | Write strobe, active high |
| bus_d_i | input | 8 | Data byte driven by the host |
| bus_d_o | output | 8 | Data byte returned to the host |
| bus_oe_o | output | 1 | Enable for driving `bus_d_o` onto the bus |
| rd_req_o | output | 1 | One-cycle read request to the register file |
| wr_req_o | output | 1 | One-cycle write request to the register file |
| req_addr_o | output | 3 | Captured register address for the requests |
| wr_data_o | output | 8 | Byte to be written with `wr_req_o` |
| rd_data_i | input | 8 | Byte read from the register at `req_addr_o` |

## Verification
A corrupted capture register or a stale armed flag appears at the ports as a wrong `req_addr_o` on the request pulse. It also shows as read data coming from the wrong location, and this happens within three clocks of the host strobe edge. A fault in the strobe edge tracking appears as a missing, doubled or wide request pulse, or as `bus_oe_o` with no matching `rd_req_o`. Deselected, late-address and tied-strobe accesses are mixed so that each of these faults changes a counted pulse or a returned byte.

// File: rtl/hbus_pkg.sv
package hbus_pkg;
  localparam int HB_ADDR_W = 3;
  localparam int HB_DATA_W = 8;
  localparam int HB_SYNC   = 2;
  // Number of single-bit control inputs: three selects, address strobe, four strobes
  localparam int HB_CTRL_W = 8;

  function automatic logic hb_selected(input logic cs_a, input logic cs_b, input logic cs_c_n);
    return cs_a & cs_b & ~cs_c_n;
  endfunction
endpackage

// File: rtl/hbus_sync.sv
module hbus_sync #(
  parameter int              W      = 1,
  parameter int              STAGES = 2,
  parameter logic [W-1:0]    RST    = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [STAGES-1:0][W-1:0] stg;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) stg[i] <= RST;
    end else begin
      stg[0] <= d;
      for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/hbus_strobe.sv
module hbus_strobe (
  input  logic clk,
  input  logic rst_n,
  input  logic rd_n_s,
  input  logic rd_s,
  input  logic wr_n_s,
  input  logic wr_s,
  output logic rd_lvl_q,
  output logic wr_act,
  output logic rd_start,
  output logic wr_end,
  output logic acc_start,
  output logic acc_end
);
  logic rd_act;
  logic rd_q, wr_q;
  logic rd_d, wr_d;
  logic wr_start, rd_end;

  always_comb begin
    rd_act   = ~rd_n_s | rd_s;
    wr_act   = ~wr_n_s | wr_s;
    rd_d     = rd_act;
    wr_d     = wr_act;
    rd_start = rd_act & ~rd_q;
    wr_start = wr_act & ~wr_q;
    rd_end   = rd_q & ~rd_act;
    wr_end   = wr_q & ~wr_act;
    acc_start = rd_start | wr_start;
    acc_end   = rd_end | wr_end;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_q <= 1'b0;
      wr_q <= 1'b0;
    end else begin
      rd_q <= rd_d;
      wr_q <= wr_d;
    end
  end

  assign rd_lvl_q = rd_q;
endmodule

// File: rtl/hbus_alatch.sv
module hbus_alatch #(
  parameter int ADDR_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              astb_n_s,
  input  logic              sel_s,
  input  logic [ADDR_W-1:0] addr_s,
  input  logic              acc_start,
  input  logic              acc_end,
  output logic [ADDR_W-1:0] lat_addr,
  output logic              lat_sel
);
  logic              astb_q, astb_fall;
  logic              armed_q, armed_d;
  logic              load;
  logic [ADDR_W-1:0] addr_q, addr_d;
  logic              sel_q, sel_d;

  always_comb begin
    astb_fall = astb_q & ~astb_n_s;
    // Transparent while the address strobe is high, captured on its fall,
    // and captured at access start when no fall has armed the hold.
    load    = astb_n_s | astb_fall | (acc_start & ~armed_q);
    armed_d = armed_q;
    if (acc_end)   armed_d = 1'b0;
    if (astb_fall) armed_d = 1'b1;
    addr_d = load ? addr_s : addr_q;
    sel_d  = load ? sel_s  : sel_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      astb_q  <= 1'b0;
      armed_q <= 1'b0;
      addr_q  <= '0;
      sel_q   <= 1'b0;
    end else begin
      astb_q  <= astb_n_s;
      armed_q <= armed_d;
      addr_q  <= addr_d;
      sel_q   <= sel_d;
    end
  end

  assign lat_addr = addr_q;
  assign lat_sel  = sel_q;
endmodule

// File: rtl/hbus_regif.sv
module hbus_regif
  import hbus_pkg::*;
#(
  parameter int ADDR_W      = HB_ADDR_W,
  parameter int DATA_W      = HB_DATA_W,
  parameter int SYNC_STAGES = HB_SYNC
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_a_i,
  input  logic              cs_b_i,
  input  logic              cs_c_n_i,
  input  logic              astb_n_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              rd_n_i,
  input  logic              rd_i,
  input  logic              wr_n_i,
  input  logic              wr_i,
  input  logic [DATA_W-1:0] bus_d_i,
  output logic [DATA_W-1:0] bus_d_o,
  output logic              bus_oe_o,
  output logic              rd_req_o,
  output logic              wr_req_o,
  output logic [ADDR_W-1:0] req_addr_o,
  output logic [DATA_W-1:0] wr_data_o,
  input  logic [DATA_W-1:0] rd_data_i
);
  localparam int SW = DATA_W + ADDR_W + HB_CTRL_W;
  // Idle levels: active-low select and both active-low strobes at 1
  localparam logic [SW-1:0] SRST = {{(DATA_W+ADDR_W){1'b0}}, 8'h2A};

  logic [1:0] rst_pipe;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_int_n = rst_pipe[1];

  logic [SW-1:0]     raw, syn;
  logic [DATA_W-1:0] d_s;
  logic [ADDR_W-1:0] a_s;
  logic              csa_s, csb_s, cscn_s, astb_s, rdn_s, rd_s, wrn_s, wr_s;
  logic              sel_s;

  assign raw = {bus_d_i, addr_i, cs_a_i, cs_b_i, cs_c_n_i, astb_n_i, rd_n_i, rd_i, wr_n_i, wr_i};

  hbus_sync #(.W(SW), .STAGES(SYNC_STAGES), .RST(SRST)) u_sync (
    .clk(clk), .rst_n(rst_int_n), .d(raw), .q(syn)
  );

  assign {d_s, a_s, csa_s, csb_s, cscn_s, astb_s, rdn_s, rd_s, wrn_s, wr_s} = syn;
  assign sel_s = hb_selected(csa_s, csb_s, cscn_s);

  logic rd_lvl_q, wr_act, rd_start, wr_end, acc_start, acc_end;

  hbus_strobe u_strobe (
    .clk(clk), .rst_n(rst_int_n),
    .rd_n_s(rdn_s), .rd_s(rd_s), .wr_n_s(wrn_s), .wr_s(wr_s),
    .rd_lvl_q(rd_lvl_q), .wr_act(wr_act), .rd_start(rd_start), .wr_end(wr_end),
    .acc_start(acc_start), .acc_end(acc_end)
  );

  logic [ADDR_W-1:0] lat_addr;
  logic              lat_sel;

  hbus_alatch #(.ADDR_W(ADDR_W)) u_alatch (
    .clk(clk), .rst_n(rst_int_n), .astb_n_s(astb_s), .sel_s(sel_s), .addr_s(a_s),
    .acc_start(acc_start), .acc_end(acc_end), .lat_addr(lat_addr), .lat_sel(lat_sel)
  );

  logic [DATA_W-1:0] wdat_q, wdat_d;
  logic              rd_pend_q, wr_pend_q;

  always_comb begin
    wdat_d = wr_act ? d_s : wdat_q;
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      wdat_q    <= '0;
      rd_pend_q <= 1'b0;
      wr_pend_q <= 1'b0;
    end else begin
      wdat_q    <= wdat_d;
      rd_pend_q <= rd_start;
      wr_pend_q <= wr_end;
    end
  end

  assign rd_req_o   = rd_pend_q & lat_sel;
  assign wr_req_o   = wr_pend_q & lat_sel;
  assign req_addr_o = lat_addr;
  assign wr_data_o  = wdat_q;
  assign bus_oe_o   = rd_lvl_q & lat_sel;
  assign bus_d_o    = bus_oe_o ? rd_data_i : '0;
endmodule

// File: rtl/hbus_regif_chk.sv
module hbus_regif_chk (
  input logic clk,
  input logic rst_n,
  input logic rd_req,
  input logic wr_req,
  input logic bus_oe
);
  AST_RD_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n) rd_req |=> !rd_req); // R3
  AST_WR_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n) wr_req |=> !wr_req); // R4
  AST_RD_DRIVES_BUS: assert property (@(posedge clk) disable iff (!rst_n) rd_req |-> bus_oe); // R5
  AST_OE_RISE_HAS_REQ: assert property (@(posedge clk) disable iff (!rst_n) $rose(bus_oe) |-> rd_req); // R3
  AST_WR_NOT_DRIVING: assert property (@(posedge clk) disable iff (!rst_n) wr_req |-> !bus_oe); // R5
endmodule

bind hbus_regif hbus_regif_chk u_chk (
  .clk(clk), .rst_n(rst_n), .rd_req(rd_req_o), .wr_req(wr_req_o), .bus_oe(bus_oe_o)
);

// File: tb/tb_hbus_regif.sv
module tb_hbus_regif;
  localparam int CLK_PERIOD = 10;

  logic       clk, rst_n;
  logic       cs_a, cs_b, cs_c_n, astb_n;
  logic [2:0] addr;
  logic       rd_n, rd, wr_n, wr;
  logic [7:0] bus_d, bus_q, wr_data, rd_data;
  logic       bus_oe, rd_req, wr_req;
  logic [2:0] req_addr;

  hbus_regif dut (
    .clk(clk), .rst_n(rst_n), .cs_a_i(cs_a), .cs_b_i(cs_b), .cs_c_n_i(cs_c_n),
    .astb_n_i(astb_n), .addr_i(addr), .rd_n_i(rd_n), .rd_i(rd), .wr_n_i(wr_n), .wr_i(wr),
    .bus_d_i(bus_d), .bus_d_o(bus_q), .bus_oe_o(bus_oe), .rd_req_o(rd_req), .wr_req_o(wr_req),
    .req_addr_o(req_addr), .wr_data_o(wr_data), .rd_data_i(rd_data)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  int tests = 0, fails = 0;
  bit done = 0;
  int rd_cnt = 0, wr_cnt = 0;
  logic [2:0] rd_addr_seen, wr_addr_seen;
  logic [7:0] wr_data_seen;
  logic [7:0] bmem [8];
  logic [7:0] exp_mem [8];

  assign rd_data = bmem[req_addr];

  // Bench register file and request monitor, sampled mid-cycle
  always @(negedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 8; i++) bmem[i] <= 8'h00;
    end else begin
      if (rd_req) begin rd_cnt++; rd_addr_seen = req_addr; end
      if (wr_req) begin
        wr_cnt++; wr_addr_seen = req_addr; wr_data_seen = wr_data;
        bmem[req_addr] <= wr_data;
      end
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // {write, active-high strobe, address strobe tied low, selected, addr[2:0], data[7:0]}
  localparam int NV = 13;
  localparam logic [14:0] VEC [NV] = '{
    {1'b1,1'b0,1'b0,1'b1,3'd5,8'hA5},
    {1'b1,1'b1,1'b1,1'b1,3'd2,8'h3C},
    {1'b0,1'b0,1'b0,1'b1,3'd5,8'h00},
    {1'b0,1'b1,1'b1,1'b1,3'd2,8'h00},
    {1'b1,1'b1,1'b0,1'b0,3'd5,8'hFF},
    {1'b0,1'b0,1'b0,1'b1,3'd5,8'h00},
    {1'b0,1'b1,1'b0,1'b0,3'd2,8'h00},
    {1'b1,1'b0,1'b1,1'b1,3'd7,8'h81},
    {1'b0,1'b0,1'b1,1'b1,3'd7,8'h00},
    {1'b1,1'b0,1'b0,1'b1,3'd0,8'h5A},
    {1'b0,1'b1,1'b0,1'b1,3'd0,8'h00},
    {1'b1,1'b1,1'b1,1'b0,3'd7,8'h00},
    {1'b0,1'b1,1'b1,1'b1,3'd7,8'h00}
  };

  task automatic set_strobe(input logic is_wr, input logic pol, input logic on);
    if (is_wr) begin
      if (pol) wr = on; else wr_n = ~on;
    end else begin
      if (pol) rd = on; else rd_n = ~on;
    end
  endtask

  task automatic access(input logic [14:0] v, input int k, input int chg);
    logic       is_wr, pol, tied, sel;
    logic [2:0] a;
    logic [7:0] d;
    int         rd0, wr0;
    string      ptag, atag;
    is_wr = v[14]; pol = v[13]; tied = v[12]; sel = v[11]; a = v[10:8]; d = v[7:0];
    rd0 = rd_cnt; wr0 = wr_cnt;
    ptag = sel ? (pol ? "R2 high strobe" : "R2 low strobe") : "R1 deselected";
    atag = tied ? "R7 tied strobe address" : "R6 strobed address";
    @(negedge clk);
    addr = a;
    {cs_a, cs_b, cs_c_n} = 3'b110;
    if (!sel) begin
      if (k % 3 == 0) cs_a = 1'b0;
      else if (k % 3 == 1) cs_b = 1'b0;
      else cs_c_n = 1'b1;
    end
    if (!tied) begin
      astb_n = 1'b1;
      repeat (3) @(negedge clk);
      astb_n = 1'b0;
      repeat (3) @(negedge clk);
    end else begin
      astb_n = 1'b0;
    end
    set_strobe(is_wr, pol, 1'b1);
    if (is_wr) bus_d = d;
    repeat (chg) @(negedge clk);
    addr = ~a;
    if (sel) cs_c_n = 1'b1; else {cs_a, cs_b, cs_c_n} = 3'b110;
    repeat (6 - chg) @(negedge clk);
    if (!is_wr) begin
      chk("R5 output enable", bus_oe, sel);
      chk("R5 read data", bus_q, sel ? exp_mem[a] : 8'h00);
    end
    set_strobe(is_wr, pol, 1'b0);
    bus_d = ~d;
    repeat (6) @(negedge clk);
    if (!tied) astb_n = 1'b1;
    if (is_wr) begin
      chk({ptag, " R4 write pulses"}, wr_cnt - wr0, sel);
      chk("R3 no read on write", rd_cnt - rd0, 0);
      if (sel) begin
        chk(atag, wr_addr_seen, a);
        chk("R4 write data", wr_data_seen, d);
        exp_mem[a] = d;
      end
    end else begin
      chk({ptag, " R3 read pulses"}, rd_cnt - rd0, sel);
      chk("R4 no write on read", wr_cnt - wr0, 0);
      if (sel) chk(atag, rd_addr_seen, a);
    end
  endtask

  initial begin
    for (int i = 0; i < 8; i++) exp_mem[i] = 8'h00;
    rst_n = 1'b0;
    {cs_a, cs_b, cs_c_n} = 3'b001; astb_n = 1'b1; addr = 3'd0;
    rd_n = 1'b1; rd = 1'b0; wr_n = 1'b1; wr = 1'b0; bus_d = 8'h00;
    repeat (3) @(negedge clk);
    chk("R8 reset rd_req", rd_req, 0);
    chk("R8 reset wr_req", wr_req, 0);
    chk("R8 reset enable", bus_oe, 0);
    chk("R8 reset bus data", bus_q, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R8 idle after reset", {rd_req, wr_req, bus_oe}, 0);

    for (int k = 0; k < NV; k++) access(VEC[k], k, 3);

    // R7: address moved one clock after the strobe edge, strobe tied low
    access({1'b1,1'b0,1'b1,1'b1,3'd3,8'hC3}, 0, 1);
    access({1'b0,1'b1,1'b1,1'b1,3'd3,8'h00}, 0, 1);

    // R8: write strobe released while reset is held
    begin
      int w0;
      @(negedge clk);
      {cs_a, cs_b, cs_c_n} = 3'b110; astb_n = 1'b0; addr = 3'd6;
      wr_n = 1'b0; bus_d = 8'h66;
      repeat (5) @(negedge clk);
      w0 = wr_cnt;
      rst_n = 1'b0;
      @(negedge clk);
      wr_n = 1'b1;
      repeat (3) @(negedge clk);
      chk("R8 outputs in reset", {rd_req, wr_req, bus_oe}, 0);
      rst_n = 1'b1;
      repeat (8) @(negedge clk);
      chk("R8 no write after reset", wr_cnt - w0, 0);
    end

    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 50000);
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule